// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block is a register-mapped controller for 32 general-purpose pins. Software sets each pin to one of two uses. In general I/O mode the pin is a plain input, or an output driven from a stored output word. In interrupt mode the pin is an input whose synchronised level is watched for an event. An event is either a level or an edge, and its polarity is chosen per pin. Each pin keeps a pending bit and an enable bit. Every enabled pending bit is ORed onto a single interrupt line.

Access uses a plain 32-bit word bus: a byte address, a write strobe, write data, and read data that follows the address combinationally. Writes take effect at the clock edge. Enable bits are turned off and on through two separate words. A write to the disable word clears every enable bit written as 0. A write to the enable word sets every enable bit written as 1. Edge events latch until software writes a one to the acknowledge word. Level events follow the pin directly. A filter-enable word can be read and written, but it has no effect on the pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, every stored word is zero and every defined offset reads zero. All pins are then general inputs with every interrupt disabled, pin_oe is zero and irq is low.
- R2: The byte offsets are 0x00 pin mode, 0x04 direction, 0x08 output data, 0x0C input level, 0x10 pending, 0x14 acknowledge, 0x18 disable, 0x1C enable, 0x20 polarity, 0x24 edge select and 0x28 filter enable. Offsets 0x14 and 0x1C are write-only and read zero. Any undefined offset reads zero. Writes to 0x0C, 0x10 and undefined offsets are ignored.
- R3: pin_oe bit n equals direction bit n (1 = output) when mode bit n is 0. It is 0 when mode bit n is 1 (interrupt mode). pin_out always equals the output data word, so that word can be loaded before a pin is turned into an output.
- R4: Offset 0x0C returns pin_in after a two-stage synchroniser. A change on pin_in that is set up before clock edge k is visible just after edge k+1.
- R5: For a pin in interrupt mode (mode bit 1) with edge-select bit 0, the pending bit is the synchronised level XOR the polarity bit (polarity 0 = active high, 1 = active low). It follows that level with no latching, and an acknowledge write does not clear it.
- R6: For a pin in interrupt mode with edge-select bit 1, the pending bit is set on a rising edge (polarity 0) or a falling edge (polarity 1) of the synchronised level. It becomes visible one cycle after the level change shows at 0x0C. It stays set until a 1 is written to that bit of offset 0x14. Bits written as 0 there have no effect.
- R7: If an acknowledge write and a new qualifying edge on the same pin fall in the same cycle, the pending bit stays set.
- R8: A write to offset 0x18 clears the enable bit of every pin whose written bit is 0 and leaves the others as they are. A write to 0x1C sets the enable bit of every pin whose written bit is 1. Reading 0x18 returns the enable vector (1 = enabled).
- R9: irq is high exactly when some pin has both its pending bit and its enable bit set.
- R10: A pin in general I/O mode never shows a pending bit, whatever its polarity and edge settings. Any latched edge is dropped when the pin leaves interrupt or edge mode.
- R11: The filter-enable word at 0x28 reads back the value last written and has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data driven toward the pins |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench aims at the cycle in which an edge is latched against an acknowledge write landing one cycle early, in the same cycle, or one cycle late. A design that let the acknowledge win would lose an interrupt in the same-cycle case. The disable and enable words are driven with mixed patterns, because a design that wrote the disable word straight into the enable vector, instead of ANDing it in, would change pins that were never named. Level pins are toggled while acknowledge writes go on, to catch a design that latches levels. Pins taken out of interrupt mode while an edge is pending are checked so that a stale pending bit cannot hold irq high.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_N  = 32;
    localparam int WORD_W = 32;

    typedef logic [PIN_N-1:0] pinvec_t;

    typedef enum logic [7:0] {
        OFS_MODE   = 8'h00,
        OFS_DIR    = 8'h04,
        OFS_DOUT   = 8'h08,
        OFS_DIN    = 8'h0C,
        OFS_PEND   = 8'h10,
        OFS_ACK    = 8'h14,
        OFS_DIS    = 8'h18,
        OFS_ENA    = 8'h1C,
        OFS_POL    = 8'h20,
        OFS_EDGE   = 8'h24,
        OFS_FILT   = 8'h28
    } reg_ofs_e;

    typedef struct packed {
        pinvec_t mode;
        pinvec_t dir;
        pinvec_t dout;
        pinvec_t pol;
        pinvec_t edge_sel;
        pinvec_t filt;
        pinvec_t en;
    } cfg_t;

    function automatic logic hits(input logic [7:0] addr, input reg_ofs_e ofs);
        return addr == 8'(ofs);
    endfunction

    function automatic pinvec_t oe_of(input cfg_t c);
        return c.dir & ~c.mode;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[LAST];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  pinvec_t           level,
    input  pinvec_t           pend,
    output cfg_t              cfg,
    output pinvec_t           ack,
    output logic [WORD_W-1:0] rdata
);
    logic [7:0] a8;
    cfg_t cfg_q;

    assign a8 = 8'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            if (hits(a8, OFS_MODE)) cfg_q.mode     <= wdata;
            if (hits(a8, OFS_DIR))  cfg_q.dir      <= wdata;
            if (hits(a8, OFS_DOUT)) cfg_q.dout     <= wdata;
            if (hits(a8, OFS_POL))  cfg_q.pol      <= wdata;
            if (hits(a8, OFS_EDGE)) cfg_q.edge_sel <= wdata;
            if (hits(a8, OFS_FILT)) cfg_q.filt     <= wdata;
            if (hits(a8, OFS_DIS))  cfg_q.en       <= cfg_q.en & wdata;
            if (hits(a8, OFS_ENA))  cfg_q.en       <= cfg_q.en | wdata;
        end
    end

    assign cfg = cfg_q;
    assign ack = (we && hits(a8, OFS_ACK)) ? wdata : '0;

    always_comb begin
        rdata = '0;
        unique case (a8)
            8'(OFS_MODE): rdata = cfg_q.mode;
            8'(OFS_DIR):  rdata = cfg_q.dir;
            8'(OFS_DOUT): rdata = cfg_q.dout;
            8'(OFS_DIN):  rdata = level;
            8'(OFS_PEND): rdata = pend;
            8'(OFS_DIS):  rdata = cfg_q.en;
            8'(OFS_POL):  rdata = cfg_q.pol;
            8'(OFS_EDGE): rdata = cfg_q.edge_sel;
            8'(OFS_FILT): rdata = cfg_q.filt;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t level,
    input  cfg_t    cfg,
    input  pinvec_t ack,
    output pinvec_t pend
);
    pinvec_t qual_prev;

    for (genvar n = 0; n < PIN_N; n++) begin : g_pin
        logic qual;
        logic rise;
        logic armed;
        logic latch_q;

        assign qual  = level[n] ^ cfg.pol[n];
        assign rise  = qual & ~qual_prev[n];
        assign armed = cfg.mode[n] & cfg.edge_sel[n];

        always_ff @(posedge clk) begin
            if (rst) begin
                qual_prev[n] <= 1'b0;
                latch_q      <= 1'b0;
            end else begin
                qual_prev[n] <= qual;
                if (!armed)        latch_q <= 1'b0;
                else if (rise)     latch_q <= 1'b1;
                else if (ack[n])   latch_q <= 1'b0;
            end
        end

        assign pend[n] = cfg.mode[n] & (cfg.edge_sel[n] ? latch_q : qual);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic              irq
);
    pinvec_t level;
    pinvec_t pend;
    pinvec_t ack;
    cfg_t    cfg;

    gpio_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (level)
    );

    gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .level (level),
        .pend  (pend),
        .cfg   (cfg),
        .ack   (ack),
        .rdata (bus_rdata)
    );

    gpio_irq_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .cfg   (cfg),
        .ack   (ack),
        .pend  (pend)
    );

    assign pin_out = cfg.dout;
    assign pin_oe  = oe_of(cfg);
    assign irq     = |(pend & cfg.en);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic [31:0]       pin_oe,
    input pinvec_t           mode,
    input pinvec_t           edge_sel,
    input pinvec_t           en,
    input pinvec_t           pend,
    input pinvec_t           ack
);
    // R1: reset leaves pins as inputs, nothing enabled, no request
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode == '0 && en == '0 && pin_oe == '0 && !irq));

    // R3: no pin drives while in interrupt mode
    a_r3_no_drive_irq_mode: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & mode) == '0);

    // R10: general I/O pins never pending
    a_r10_gpio_not_pending: assert property (@(posedge clk) disable iff (rst)
        (pend & ~mode) == '0);

    // R6: a latched edge survives until acknowledged
    a_r6_edge_holds: assert property (@(posedge clk) disable iff (rst)
        ((pend & mode & edge_sel & ~ack) != '0) |=>
        (($past(pend & mode & edge_sel & ~ack) & mode & edge_sel & ~pend) == '0));

    // R8: enable word sets the named bits
    a_r8_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_we && 8'(bus_addr) == 8'(OFS_ENA)) |=>
        ((en & $past(bus_wdata)) == $past(bus_wdata)));

    // R8: disable word clears bits written as zero
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && 8'(bus_addr) == 8'(OFS_DIS)) |=>
        ((en & ~$past(bus_wdata)) == '0));

    // R9: nothing enabled means no request
    a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .mode      (cfg.mode),
    .edge_sel  (cfg.edge_sel),
    .en        (cfg.en),
    .pend      (pend),
    .ack       (ack)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int checks = 0;
    int bad = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Behavioural reference state
    logic [31:0] m_mode, m_dir, m_dout, m_pol, m_edge, m_filt, m_en;
    logic [31:0] m_s1, m_s2, m_prev, m_latch;

    function automatic logic [31:0] m_pend();
        logic [31:0] p;
        for (int n = 0; n < 32; n++) begin
            if (!m_mode[n])      p[n] = 1'b0;
            else if (m_edge[n])  p[n] = m_latch[n];
            else                 p[n] = m_s2[n] ^ m_pol[n];
        end
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_mode;
            8'h04: return m_dir;
            8'h08: return m_dout;
            8'h0C: return m_s2;
            8'h10: return m_pend();
            8'h18: return m_en;
            8'h20: return m_pol;
            8'h24: return m_edge;
            8'h28: return m_filt;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_dir = 0; m_dout = 0; m_pol = 0; m_edge = 0;
            m_filt = 0; m_en = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_latch = 0;
        end else begin
            logic [31:0] q, ackv;
            q    = m_s2 ^ m_pol;
            ackv = (bus_we && bus_addr == 8'h14) ? bus_wdata : 32'h0;
            for (int n = 0; n < 32; n++) begin
                if (!(m_mode[n] && m_edge[n]))      m_latch[n] = 1'b0;
                else if (q[n] && !m_prev[n])        m_latch[n] = 1'b1;
                else if (ackv[n])                   m_latch[n] = 1'b0;
            end
            m_prev = q;
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (bus_we) begin
                case (bus_addr)
                    8'h00: m_mode = bus_wdata;
                    8'h04: m_dir  = bus_wdata;
                    8'h08: m_dout = bus_wdata;
                    8'h18: m_en   = m_en & bus_wdata;
                    8'h1C: m_en   = m_en | bus_wdata;
                    8'h20: m_pol  = bus_wdata;
                    8'h24: m_edge = bus_wdata;
                    8'h28: m_filt = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check32(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every cycle, 2 ns after the active edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            logic [31:0] pe;
            pe = m_pend();
            check32("rdata", bus_rdata, m_read(bus_addr));
            check32("pin_out (R3)", pin_out, m_dout);
            check32("pin_oe (R3)", pin_oe, m_dir & ~m_mode);
            check32("irq (R9)", {31'b0, irq}, {31'b0, |(pe & m_en)});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic look(input logic [7:0] a, input int n);
        @(negedge clk);
        bus_addr = a;
        idle(n);
    endtask

    task automatic scan_all();
        for (int a = 0; a <= 8'h34; a += 4) look(8'(a), 1);
        look(8'h02, 1);
        look(8'hFC, 1);
    endtask

    initial begin
        idle(3);
        // R1: reset state seen directly at the ports
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        check32("pin_oe after reset", pin_oe, 32'h0);
        check32("irq after reset", {31'b0, irq}, 32'h0);
        scan_all();

        // R3: output data before direction, then mode overrides
        tag = "R3";
        wr(8'h08, 32'hA5A5_0F0F);
        look(8'h08, 2);
        wr(8'h04, 32'hFFFF_0000);
        wr(8'h00, 32'h0F00_0000);
        look(8'h04, 2);
        wr(8'h00, 32'h0);

        // R2: read-only, write-only and undefined offsets
        tag = "R2";
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0);
        scan_all();

        // R4: synchronised input level
        tag = "R4";
        look(8'h0C, 1);
        foreach (pin_in[i]) ;
        pin_in = 32'h1234_5678; idle(3);
        pin_in = 32'hFEDC_BA98; idle(1);
        pin_in = 32'h0000_FFFF; idle(4);
        pin_in = 32'h0;         idle(3);

        // R5: level sensing, both polarities, acknowledge has no hold
        tag = "R5";
        wr(8'h20, 32'h0000_000A);
        wr(8'h24, 32'h0);
        wr(8'h00, 32'h0000_000F);
        wr(8'h1C, 32'h0000_000F);
        look(8'h10, 3);
        for (int k = 0; k < 16; k++) begin
            pin_in[3:0] = 4'(k);
            idle(3);
        end
        wr(8'h14, 32'hFFFF_FFFF);
        look(8'h10, 3);

        // R9: disable everything, pending remains visible
        tag = "R9";
        wr(8'h18, 32'h0);
        look(8'h10, 2);
        wr(8'h1C, 32'h0000_0003);
        look(8'h10, 2);
        pin_in = 32'h0; idle(3);

        // R6: edge sensing, rising and falling, acknowledge with zero bits
        tag = "R6";
        wr(8'h00, 32'h0000_0F00);
        wr(8'h20, 32'h0000_0A00);
        wr(8'h24, 32'h0000_0F00);
        wr(8'h1C, 32'h0000_0F00);
        pin_in[11:8] = 4'hA; idle(4);
        look(8'h10, 2);
        pin_in[11:8] = 4'h5; idle(4);
        wr(8'h14, 32'h0);
        look(8'h10, 2);
        wr(8'h14, 32'h0000_0500);
        look(8'h10, 2);
        wr(8'h14, 32'h0000_0A00);
        look(8'h10, 2);
        pin_in[11:8] = 4'hA; idle(4);
        wr(8'h14, 32'h0000_0F00);
        look(8'h10, 2);

        // R7: acknowledge landing around the latching cycle
        tag = "R7";
        for (int off = 0; off < 4; off++) begin
            @(negedge clk);
            pin_in[8] = 1'b0;
            idle(4);
            wr(8'h14, 32'h0000_0100);
            @(negedge clk);
            pin_in[8] = 1'b1;
            idle(off);
            bus_addr = 8'h14; bus_we = 1'b1; bus_wdata = 32'h0000_0100;
            @(negedge clk);
            bus_we = 1'b0; bus_addr = 8'h10;
            idle(3);
        end

        // R8: disable and enable words with mixed patterns
        tag = "R8";
        wr(8'h1C, 32'hF0F0_1234);
        look(8'h18, 1);
        wr(8'h18, 32'hFFFF_FEFF);
        look(8'h18, 1);
        wr(8'h18, 32'h5555_AAAA);
        look(8'h18, 1);
        wr(8'h1C, 32'h0000_0100);
        look(8'h10, 2);

        // R10: leave interrupt mode with an edge latched
        tag = "R10";
        pin_in[9] = 1'b0; idle(4);
        pin_in[9] = 1'b1; idle(4);
        wr(8'h00, 32'h0000_0000);
        look(8'h10, 3);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        pin_in = 32'hFFFF_FFFF; idle(3);
        pin_in = 32'h0;         idle(3);
        wr(8'h00, 32'h0000_0F00);
        look(8'h10, 3);

        // R11: filter word is stored only
        tag = "R11";
        wr(8'h28, 32'hDEAD_BEEF);
        look(8'h28, 2);
        look(8'h10, 2);
        wr(8'h28, 32'h0);
        scan_all();

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule